// File: doc/BRIEF.md
# Shared RAM Arbiter with Read-Ahead and Write-Behind Host Port

This block lets two masters use one single-ported RAM: a host processor and a network MAC. The host does not address the RAM directly. It works through a pointer and a one-word data register. Loading the pointer starts a fetch of that word. A host read returns the register at once and starts a fetch of the following word. A host write is taken into the register in the same clock and is written to RAM later. Because of this, no host access ever waits for the memory.

Every RAM cycle takes two clocks. In the first clock the port drives the address, the enable and the write data. In the second clock the synchronous RAM returns read data. The owner of the next cycle is chosen only when a cycle ends or when the RAM is idle. The MAC has priority at that point. The party whose cycle is ending is never chosen again at once, so each side waits at most one cycle of the other side. The MAC may access any address at any time.

Top module: `ram_share_arb`

## Requirements
- R1: After reset, `hst_wait`, `hst_dvalid`, `ram_en` and `mac_gnt` are all 0.
- R2: `ram_en` is never high in two consecutive clocks. Each memory cycle is one drive clock followed by one data-return clock.
- R3: A pointer load to address A is accepted while `hst_wait` is low. It clears `hst_dvalid` and fetches A. When the fetch ends, `hst_rdata` equals RAM[A], `hst_dvalid` is 1 and the pointer holds A+1.
- R4: A host read is accepted when `hst_wait` is low and `hst_dvalid` is high. In the same clock `hst_rdata` holds the word of the last fetch. The read then fetches the word at the pointer and advances the pointer, so successive reads return RAM[A], RAM[A+1], and so on.
- R5: A host write is accepted in the clock it is presented, provided `hst_wait` is low. Its data is written to RAM at the pointer in a later cycle, and then the pointer advances by one. `hst_dvalid` stays 0 until the next pointer load.
- R6: While `hst_wait` is high, host pointer loads, reads and writes have no effect. A read presented while `hst_dvalid` is low also has no effect, and it starts no memory cycle.
- R7: If several host commands are accepted in the same clock, a pointer load wins over a write, and a write wins over a read. The commands that lose are dropped.
- R8: At a cycle boundary, or while the RAM is idle, a MAC request wins over a pending host operation. The party whose cycle is just ending is not picked for the next cycle.
- R9: A MAC request held high gets `mac_gnt` after at most 3 waiting clocks.
- R10: In the clock where `mac_gnt` is high, the RAM is driven with `mac_addr`, `mac_we` and `mac_wdata`. For a read, `mac_rvalid` is high in the next clock and `mac_rdata` carries the word.
- R11: Pointer advance wraps from the top address (2^AW-1) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_ptr_ld | input | 1 | Host pointer load strobe |
| hst_ptr_addr | input | AW | Address to load into the pointer |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | DW | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | DW | Data register contents |
| hst_wait | output | 1 | A posted write or a fetch is still pending |
| hst_dvalid | output | 1 | The data register holds fetched data |
| mac_req | input | 1 | MAC access request, held until granted |
| mac_we | input | 1 | MAC write enable |
| mac_addr | input | AW | MAC address |
| mac_wdata | input | DW | MAC write data |
| mac_gnt | output | 1 | MAC owns the RAM in this drive clock |
| mac_rdata | output | DW | MAC read data |
| mac_rvalid | output | 1 | `mac_rdata` is valid |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one clock after `ram_en` |

## Verification
Random host traffic mixes pointer loads, sequential reads and posted writes in the lower part of the memory. At the same time, random MAC reads and writes with random gaps run in the upper part. Read data that comes back in the wrong order would expose a pointer that advances at the wrong time. A bad read-back would expose a lost write-behind, and the MAC wait counts show whether the latency bound holds under contention. Directed cases cover the following:
- commands presented while busy
- a read presented with no valid data
- all three host strobes at once
- a MAC request that collides with a pending host fetch
- pointer wrap at the top address

// File: rtl/rarb_pkg.sv
package rarb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MAC  = 2'd2
  } owner_t;

  // Owner of the next memory cycle. fin marks the data-return clock of cur,
  // and the party finishing a cycle is skipped once.
  function automatic owner_t pick_owner(input logic   mac_rq,
                                        input logic   host_rq,
                                        input owner_t cur,
                                        input logic   fin);
    logic mac_ok;
    logic host_ok;
    mac_ok  = mac_rq  && !(fin && cur == OWN_MAC);
    host_ok = host_rq && !(fin && cur == OWN_HOST);
    if (mac_ok)       return OWN_MAC;
    else if (host_ok) return OWN_HOST;
    else              return OWN_NONE;
  endfunction

endpackage

// File: rtl/rarb_slot_sched.sv
module rarb_slot_sched
  import rarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mac_req,
  input  logic   host_pend,
  output owner_t owner,
  output logic   phase_b,
  output logic   mac_gnt,
  output logic   host_go,
  output logic   host_done
);

  logic   slot_free;
  owner_t nxt_owner;
  logic [1:0] mac_wcnt;

  assign slot_free = (owner == OWN_NONE) || phase_b;
  assign nxt_owner = pick_owner(mac_req, host_pend, owner, phase_b);

  assign mac_gnt   = (owner == OWN_MAC)  && !phase_b;
  assign host_go   = (owner == OWN_HOST) && !phase_b;
  assign host_done = (owner == OWN_HOST) &&  phase_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner   <= OWN_NONE;
      phase_b <= 1'b0;
    end else if (slot_free) begin
      owner   <= nxt_owner;
      phase_b <= 1'b0;
    end else begin
      phase_b <= 1'b1;
    end
  end

  // Waiting clocks of the current MAC request, used by the latency check.
  always_ff @(posedge clk) begin
    if (!rst_n)
      mac_wcnt <= 2'd0;
    else if (mac_req && !mac_gnt)
      mac_wcnt <= (mac_wcnt == 2'd3) ? mac_wcnt : mac_wcnt + 2'd1;
    else
      mac_wcnt <= 2'd0;
  end

  AST_MAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req && !mac_gnt) |-> (mac_wcnt < 2'd3)); // R9

  AST_MAC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && mac_req && !(owner == OWN_MAC && phase_b)) |=> (owner == OWN_MAC && !phase_b)); // R8

endmodule

// File: rtl/rarb_host_buf.sv
module rarb_host_buf #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          done,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] dreg,
  output logic          dvalid,
  output logic          pend,
  output logic          pend_we
);

  localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + PTR_ONE;
  endfunction

  logic acc_ld;
  logic acc_wr;
  logic acc_rd;

  assign acc_ld = ld && !pend;
  assign acc_wr = wr && !pend && !ld;
  assign acc_rd = rd && !pend && !ld && !wr && dvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      dreg    <= '0;
      dvalid  <= 1'b0;
      pend    <= 1'b0;
      pend_we <= 1'b0;
    end else if (acc_ld) begin
      ptr     <= ld_addr;
      dvalid  <= 1'b0;
      pend    <= 1'b1;
      pend_we <= 1'b0;
    end else if (acc_wr) begin
      dreg    <= wdata;
      dvalid  <= 1'b0;
      pend    <= 1'b1;
      pend_we <= 1'b1;
    end else if (acc_rd) begin
      dvalid  <= 1'b0;
      pend    <= 1'b1;
      pend_we <= 1'b0;
    end else if (done) begin
      pend <= 1'b0;
      ptr  <= ptr_step(ptr);
      if (!pend_we) begin
        dreg   <= ram_rdata;
        dvalid <= 1'b1;
      end
    end
  end

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pend_we) |=> dvalid); // R3

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done) |=> ($stable(ptr) && $stable(dreg))); // R6

  AST_WRITE_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pend_we) |-> !dvalid); // R5

endmodule

// File: rtl/ram_share_arb.sv
module ram_share_arb
  import rarb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_ptr_ld,
  input  logic [AW-1:0] hst_ptr_addr,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  input  logic          hst_rd,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_wait,
  output logic          hst_dvalid,
  input  logic          mac_req,
  input  logic          mac_we,
  input  logic [AW-1:0] mac_addr,
  input  logic [DW-1:0] mac_wdata,
  output logic          mac_gnt,
  output logic [DW-1:0] mac_rdata,
  output logic          mac_rvalid,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);

  owner_t        owner;
  logic          phase_b;
  logic          host_go;
  logic          host_done;
  logic          pend;
  logic          pend_we;
  logic [AW-1:0] ptr;
  logic [DW-1:0] dreg;
  logic          mac_we_q;

  rarb_slot_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .mac_req   (mac_req),
    .host_pend (pend),
    .owner     (owner),
    .phase_b   (phase_b),
    .mac_gnt   (mac_gnt),
    .host_go   (host_go),
    .host_done (host_done)
  );

  rarb_host_buf #(.AW(AW), .DW(DW)) u_hbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (hst_ptr_ld),
    .ld_addr   (hst_ptr_addr),
    .wr        (hst_wr),
    .wdata     (hst_wdata),
    .rd        (hst_rd),
    .done      (host_done),
    .ram_rdata (ram_rdata),
    .ptr       (ptr),
    .dreg      (dreg),
    .dvalid    (hst_dvalid),
    .pend      (pend),
    .pend_we   (pend_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      mac_we_q <= 1'b0;
    else if (mac_gnt)
      mac_we_q <= mac_we;
  end

  assign hst_rdata  = dreg;
  assign hst_wait   = pend;

  assign ram_en     = mac_gnt || host_go;
  assign ram_we     = mac_gnt ? mac_we    : (host_go && pend_we);
  assign ram_addr   = mac_gnt ? mac_addr  : ptr;
  assign ram_wdata  = mac_gnt ? mac_wdata : dreg;

  assign mac_rdata  = ram_rdata;
  assign mac_rvalid = (owner == OWN_MAC) && phase_b && !mac_we_q;

  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> !ram_en); // R2

  AST_MAC_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    mac_rvalid |-> $past(mac_gnt && !mac_we)); // R10

endmodule

// File: tb/sim_ram_share_arb.sv
`timescale 1ns/1ps
module sim_ram_share_arb;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_ptr_ld = 1'b0;
  logic [AW-1:0] hst_ptr_addr = '0;
  logic          hst_wr = 1'b0;
  logic [DW-1:0] hst_wdata = '0;
  logic          hst_rd = 1'b0;
  logic [DW-1:0] hst_rdata;
  logic          hst_wait;
  logic          hst_dvalid;
  logic          mac_req = 1'b0;
  logic          mac_we = 1'b0;
  logic [AW-1:0] mac_addr = '0;
  logic [DW-1:0] mac_wdata = '0;
  logic          mac_gnt;
  logic [DW-1:0] mac_rdata;
  logic          mac_rvalid;
  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int back2back = 0;
  int bptr = 0;
  bit hv = 0;
  bit prev_en = 0;

  always #2 clk = ~clk;

  ram_share_arb #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .hst_ptr_ld(hst_ptr_ld), .hst_ptr_addr(hst_ptr_addr),
    .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_rd(hst_rd),
    .hst_rdata(hst_rdata), .hst_wait(hst_wait), .hst_dvalid(hst_dvalid),
    .mac_req(mac_req), .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata),
    .mac_gnt(mac_gnt), .mac_rdata(mac_rdata), .mac_rvalid(mac_rvalid),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [DW-1:0] seed_val(input int i);
    return DW'((i * 37 + 5) % 256);
  endfunction

  function automatic int bump(input int a);
    return (a + 1) % DEPTH;
  endfunction

  function automatic int back1(input int a);
    return (a + DEPTH - 1) % DEPTH;
  endfunction

  // Synchronous single-port RAM model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_val(i);
    end else if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_en && prev_en) back2back++;
      prev_en = ram_en;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic h_ready(input bit need_valid);
    while (hst_wait || (need_valid && !hst_dvalid)) @(negedge clk);
  endtask

  task automatic h_load(input int a);
    h_ready(1'b0);
    hst_ptr_ld = 1'b1;
    hst_ptr_addr = AW'(a);
    @(negedge clk);
    hst_ptr_ld = 1'b0;
    bptr = bump(a);
    hv = 1'b1;
  endtask

  task automatic h_read(input string req);
    h_ready(1'b1);
    chk(hst_rdata == shadow[back1(bptr)], req, hst_rdata, shadow[back1(bptr)]);
    hst_rd = 1'b1;
    @(negedge clk);
    hst_rd = 1'b0;
    bptr = bump(bptr);
  endtask

  task automatic h_write(input logic [DW-1:0] d);
    h_ready(1'b0);
    hst_wr = 1'b1;
    hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
    shadow[bptr] = d;
    bptr = bump(bptr);
    hv = 1'b0;
  endtask

  task automatic m_access(input bit we, input int a, input logic [DW-1:0] d);
    int wcnt;
    wcnt = 0;
    mac_req = 1'b1;
    mac_we = we;
    mac_addr = AW'(a);
    mac_wdata = d;
    @(negedge clk);
    while (!mac_gnt) begin
      wcnt++;
      @(negedge clk);
    end
    chk(wcnt <= 3, "R9", wcnt, 3);
    chk(ram_en && ram_addr == AW'(a) && ram_we == we, "R10", int'(ram_addr), a);
    mac_req = 1'b0;
    if (we) shadow[a] = d;
    @(negedge clk);
    if (!we)
      chk(mac_rvalid && mac_rdata == shadow[a], "R10", mac_rdata, shadow[a]);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h5eed);
    for (int i = 0; i < DEPTH; i++) shadow[i] = seed_val(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!hst_wait && !hst_dvalid && !ram_en && !mac_gnt, "R1",
        {hst_wait, hst_dvalid, ram_en, mac_gnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hst_wait && !hst_dvalid && !ram_en && !mac_gnt, "R1",
        {hst_wait, hst_dvalid, ram_en, mac_gnt}, 0);

    // R3/R4: sequential reads from a fresh load
    h_load(5);
    h_read("R3");
    h_read("R4");
    h_read("R4");

    // Random mixed traffic, host low region, MAC high region
    fork
      begin
        for (int n = 0; n < 250; n++) begin
          if (n % 12 == 0) h_load(int'($urandom % 32'h2C0));
          else if (hv && ($urandom % 2 == 0)) h_read("R4");
          else h_write(DW'($urandom));
          repeat ($urandom % 3) @(negedge clk);
        end
      end
      begin
        for (int n = 0; n < 150; n++) begin
          m_access(bit'($urandom % 2), int'(32'h300 + ($urandom % 32'h100)), DW'($urandom));
          repeat ($urandom % 4) @(negedge clk);
        end
      end
    join

    // R6: commands while busy are ignored
    h_load(16);
    chk(hst_wait, "R6", hst_wait, 1);
    hst_ptr_ld = 1'b1; hst_ptr_addr = AW'(10'h200);
    hst_wr = 1'b1; hst_wdata = 8'hAA;
    @(negedge clk);
    hst_ptr_ld = 1'b0; hst_wr = 1'b0;
    h_read("R6");
    h_ready(1'b1);
    chk(mem[16] == shadow[16], "R6", mem[16], shadow[16]);

    // R5: posted writes land at the pointer, dvalid stays low
    h_load(32);
    h_write(8'h11);
    chk(hst_wait, "R5", hst_wait, 1);
    h_write(8'h22);
    h_ready(1'b0);
    chk(mem[33] == 8'h11, "R5", mem[33], 8'h11);
    chk(mem[34] == 8'h22, "R5", mem[34], 8'h22);
    chk(!hst_dvalid, "R5", hst_dvalid, 0);

    // R6: read with no valid data starts nothing
    hst_rd = 1'b1;
    @(negedge clk);
    hst_rd = 1'b0;
    chk(!hst_wait && !ram_en, "R6", {hst_wait, ram_en}, 0);
    @(negedge clk);
    chk(!ram_en, "R6", ram_en, 0);

    // R7: load beats write beats read
    begin
      int oldp;
      oldp = bptr;
      h_ready(1'b0);
      hst_ptr_ld = 1'b1; hst_ptr_addr = AW'(64);
      hst_wr = 1'b1; hst_wdata = 8'h77; hst_rd = 1'b1;
      @(negedge clk);
      hst_ptr_ld = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0;
      bptr = 65; hv = 1'b1;
      h_read("R7");
      h_ready(1'b1);
      chk(mem[oldp] == shadow[oldp], "R7", mem[oldp], shadow[oldp]);
    end

    // R8: MAC wins over a pending host fetch
    h_ready(1'b1);
    hst_ptr_ld = 1'b1; hst_ptr_addr = AW'(128);
    @(negedge clk);
    hst_ptr_ld = 1'b0;
    mac_req = 1'b1; mac_we = 1'b0; mac_addr = AW'(10'h3F0);
    @(negedge clk);
    chk(mac_gnt && ram_addr == AW'(10'h3F0), "R8", int'(ram_addr), 10'h3F0);
    mac_req = 1'b0;
    @(negedge clk);
    chk(mac_rvalid && mac_rdata == shadow[10'h3F0], "R10", mac_rdata, shadow[10'h3F0]);
    bptr = 129; hv = 1'b1;
    h_read("R8");

    // R11: pointer wraps from the top address to zero
    h_load(DEPTH - 1);
    h_read("R11");
    h_read("R11");
    h_ready(1'b1);

    // R2: never two consecutive RAM enables
    chk(back2back == 0, "R2", back2back, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule